// File: doc/BRIEF.md
# SCL Low-Hold Extension Monitor

This block watches an I2C clock and data pair without driving them and measures how much longer than intended each SCL low phase lasted. The master side reports the number of clock cycles it meant the low phase to last, and separately raises a "released" flag once it has stopped pulling SCL down. When the line stays low past that release and the excess over the intended low time is larger than a programmable threshold, the block raises a one-cycle event. The event carries the excess in cycles and two tags. The first tag says whether the phase was the acknowledge slot of a byte. The second gives the transfer direction.

Running statistics sit beside the per-event data: the largest excess seen, a saturating event count, and sticky read and write hit flags. A statistics clear input resets the maximum and the hit flags. Every START condition advances a transaction identifier, so captured events can be matched with software logs. Two bus-idle indications are also provided. One marks whether a START began from a free bus. The other marks whether the bus stayed free for a fixed window after a STOP.

Top module: `scl_stretch_mon`

## Requirements
- R1: Both raw lines are synchronized and must show the same value on three consecutive synchronized samples before the filtered line takes it, so a pulse shorter than three cycles has no effect. An accepted change appears on the filtered line four clock edges after the raw change is first sampled.
- R2: The excess is the number of cycles the filtered SCL was low, minus `exp_low`, floored at zero. The low counter saturates at 2^CNT_W-1 and does not wrap.
- R3: `evt_valid` pulses for one cycle, one clock after the filtered SCL rises. It pulses only if `mst_rel` was seen high while the filtered SCL was low in that phase, and only if the excess is strictly greater than `thresh`.
- R4: `evt_ack` is 1 when `bit_pos` equals 8 (the acknowledge slot) at the rising edge that closes the phase, and 0 for positions 0 to 7.
- R5: `evt_rd` copies `dir_rd` (1 = read, 0 = write) for the event. `hit_rd` and `hit_wr` latch high on the first event of their direction.
- R6: `max_ext` holds the largest event excess. A `stats_clr` cycle sets it to zero and clears both hit flags. If an event fires in that same cycle, the event's excess and hit are loaded instead.
- R7: `evt_cnt` increments by one per event and saturates at its maximum value. `stats_clr` does not clear it.
- R8: A START is the filtered SDA falling while the filtered SCL is high, and it increments `txn_id` modulo 2^ID_W.
- R9: At each START, `idle_before_start` becomes 1 if no START has occurred since the last STOP (or since reset), and 0 for a repeated START.
- R10: A STOP is the filtered SDA rising while the filtered SCL is high. `idle_after_stop` becomes 1 once both filtered lines have been high for IDLE_CYC cycles following a STOP. It is cleared by every START and STOP.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| mst_rel | input | 1 | Master has stopped pulling SCL low |
| exp_low | input | CNT_W | Intended low time in cycles |
| thresh | input | CNT_W | Excess that must be exceeded to raise an event |
| dir_rd | input | 1 | Current transfer direction, 1 = read |
| bit_pos | input | BIT_W | Bit index within the byte, 8 = acknowledge slot |
| stats_clr | input | 1 | Clears maximum and hit flags |
| evt_valid | output | 1 | One-cycle event pulse |
| evt_ext | output | CNT_W | Excess of the last event |
| evt_ack | output | 1 | Last event fell in the acknowledge slot |
| evt_rd | output | 1 | Last event was during a read |
| max_ext | output | CNT_W | Largest excess since last clear |
| evt_cnt | output | EVT_W | Saturating event count |
| hit_rd | output | 1 | An event occurred during a read |
| hit_wr | output | 1 | An event occurred during a write |
| txn_id | output | ID_W | Transaction identifier |
| idle_before_start | output | 1 | Last START began from a free bus |
| idle_after_stop | output | 1 | Bus stayed free for the window after the last STOP |

## Verification
The bench checks an excess exactly equal to the threshold. A comparison off by one there would raise a spurious event. It checks a long hold with no master release, where a missing release gate would report an event. It checks a two-cycle high blip inside a long low, which a weak filter would split into two short phases and so lose the real excess. It also checks a low phase longer than the counter range, where a wrapping counter would report a tiny excess, and a repeated START and a START inside the post-STOP window, where faulty idle bookkeeping would show the bus as free.

// File: rtl/scl_mon_pkg.sv
package scl_mon_pkg;
  localparam int ACK_POS = 8;
  typedef enum logic {DIR_WR = 1'b0, DIR_RD = 1'b1} xfer_dir_e;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  logic s1, s2;
  logic [1:0] hist;
  logic agree;

  // three consecutive synchronized samples must match
  assign agree = (s2 == hist[0]) && (hist[0] == hist[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      hist  <= 2'b11;
      clean <= 1'b1;
    end else begin
      s1   <= raw;
      s2   <= s1;
      hist <= {hist[0], s2};
      if (agree) clean <= s2;
    end
  end
endmodule

// File: rtl/scl_stretch_meas.sv
module scl_stretch_meas #(
  parameter int CNT_W = 16,
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             mst_rel,
  input  logic [CNT_W-1:0] exp_low,
  input  logic [CNT_W-1:0] thresh,
  input  logic             ack_slot,
  input  logic             dir_rd,
  input  logic             stats_clr,
  output logic             evt_valid,
  output logic [CNT_W-1:0] evt_ext,
  output logic             evt_ack,
  output logic             evt_rd,
  output logic [CNT_W-1:0] max_ext,
  output logic [EVT_W-1:0] evt_cnt,
  output logic             hit_rd,
  output logic             hit_wr
);
  localparam logic [CNT_W-1:0] LOW_MAX = '1;
  localparam logic [EVT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] low_step(input logic [CNT_W-1:0] v);
    return (v == LOW_MAX) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] excess(input logic [CNT_W-1:0] seen,
                                               input logic [CNT_W-1:0] want);
    return (seen > want) ? seen - want : '0;
  endfunction

  logic             scl_q, held;
  logic [CNT_W-1:0] low_cnt, ext_now;
  logic             fall_w, rise_w, fire_w;

  assign fall_w  = ~scl_f & scl_q;
  assign rise_w  = scl_f & ~scl_q;
  assign ext_now = excess(low_cnt, exp_low);
  assign fire_w  = rise_w & held & (ext_now > thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      held      <= 1'b0;
      low_cnt   <= '0;
      evt_valid <= 1'b0;
      evt_ext   <= '0;
      evt_ack   <= 1'b0;
      evt_rd    <= 1'b0;
      max_ext   <= '0;
      evt_cnt   <= '0;
      hit_rd    <= 1'b0;
      hit_wr    <= 1'b0;
    end else begin
      scl_q     <= scl_f;
      evt_valid <= fire_w;
      if (!scl_f) low_cnt <= fall_w ? CNT_W'(1) : low_step(low_cnt);
      if (fall_w) held <= mst_rel;
      else if (!scl_f && mst_rel) held <= 1'b1;
      if (fire_w) begin
        evt_ext <= ext_now;
        evt_ack <= ack_slot;
        evt_rd  <= dir_rd;
        if (evt_cnt != CNT_MAX) evt_cnt <= evt_cnt + EVT_W'(1);
      end
      if (stats_clr) begin
        max_ext <= fire_w ? ext_now : '0;
        hit_rd  <= fire_w & dir_rd;
        hit_wr  <= fire_w & ~dir_rd;
      end else if (fire_w) begin
        if (ext_now > max_ext) max_ext <= ext_now;
        if (dir_rd) hit_rd <= 1'b1;
        else        hit_wr <= 1'b1;
      end
    end
  end

  AST_EVT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(rise_w)); // R3
  AST_EVT_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_ext > $past(thresh)); // R3
  AST_LOW_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_f && !scl_q && low_cnt == LOW_MAX) |=> low_cnt == LOW_MAX); // R2
  AST_MAX_COVERS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> max_ext >= evt_ext); // R6
  AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stats_clr) |-> max_ext >= $past(max_ext)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && $past(evt_cnt) != CNT_MAX) |-> evt_cnt == $past(evt_cnt) + EVT_W'(1)); // R7
endmodule

// File: rtl/scl_bus_cond.sv
module scl_bus_cond #(
  parameter int ID_W     = 8,
  parameter int IDLE_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_f,
  input  logic            sda_f,
  output logic [ID_W-1:0] txn_id,
  output logic            idle_before_start,
  output logic            idle_after_stop
);
  localparam int IC_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
  localparam logic [IC_W-1:0] IC_LAST = IC_W'(IDLE_CYC - 1);

  logic scl_q, sda_q, in_txn, armed;
  logic [IC_W-1:0] icnt;
  logic start_w, stop_w;

  assign start_w = scl_f & scl_q & ~sda_f & sda_q;
  assign stop_w  = scl_f & scl_q & sda_f & ~sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      in_txn <= 1'b0;
      armed <= 1'b0;
      icnt <= '0;
      txn_id <= '0;
      idle_before_start <= 1'b0;
      idle_after_stop <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_w) begin
        txn_id            <= txn_id + ID_W'(1);
        idle_before_start <= ~in_txn;
        in_txn            <= 1'b1;
        idle_after_stop   <= 1'b0;
        armed             <= 1'b0;
      end else if (stop_w) begin
        in_txn          <= 1'b0;
        idle_after_stop <= 1'b0;
        armed           <= 1'b1;
        icnt            <= '0;
      end else if (armed) begin
        if (scl_f && sda_f) begin
          if (icnt == IC_LAST) begin
            idle_after_stop <= 1'b1;
            armed           <= 1'b0;
          end else begin
            icnt <= icnt + IC_W'(1);
          end
        end else begin
          armed <= 1'b0;
        end
      end
    end
  end

  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> txn_id == $past(txn_id) + ID_W'(1)); // R8
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_w |=> $stable(txn_id)); // R8
  AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w || stop_w) |=> !idle_after_stop); // R10
endmodule

// File: rtl/scl_stretch_mon.sv
module scl_stretch_mon
  import scl_mon_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int EVT_W    = 16,
  parameter int ID_W     = 8,
  parameter int BIT_W    = 4,
  parameter int IDLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             mst_rel,
  input  logic [CNT_W-1:0] exp_low,
  input  logic [CNT_W-1:0] thresh,
  input  logic             dir_rd,
  input  logic [BIT_W-1:0] bit_pos,
  input  logic             stats_clr,
  output logic             evt_valid,
  output logic [CNT_W-1:0] evt_ext,
  output logic             evt_ack,
  output logic             evt_rd,
  output logic [CNT_W-1:0] max_ext,
  output logic [EVT_W-1:0] evt_cnt,
  output logic             hit_rd,
  output logic             hit_wr,
  output logic [ID_W-1:0]  txn_id,
  output logic             idle_before_start,
  output logic             idle_after_stop
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v, clean_v;
  logic ack_slot;

  assign raw_v    = {sda_in, scl_in};
  assign ack_slot = (bit_pos == BIT_W'(ACK_POS));

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    scl_line_filter u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_v[gi]),
      .clean(clean_v[gi])
    );
  end

  scl_stretch_meas #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_meas (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (clean_v[0]),
    .mst_rel  (mst_rel),
    .exp_low  (exp_low),
    .thresh   (thresh),
    .ack_slot (ack_slot),
    .dir_rd   (dir_rd == DIR_RD),
    .stats_clr(stats_clr),
    .evt_valid(evt_valid),
    .evt_ext  (evt_ext),
    .evt_ack  (evt_ack),
    .evt_rd   (evt_rd),
    .max_ext  (max_ext),
    .evt_cnt  (evt_cnt),
    .hit_rd   (hit_rd),
    .hit_wr   (hit_wr)
  );

  scl_bus_cond #(.ID_W(ID_W), .IDLE_CYC(IDLE_CYC)) u_bus (
    .clk              (clk),
    .rst_n            (rst_n),
    .scl_f            (clean_v[0]),
    .sda_f            (clean_v[1]),
    .txn_id           (txn_id),
    .idle_before_start(idle_before_start),
    .idle_after_stop  (idle_after_stop)
  );

  AST_HITS_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hit_rd) || $rose(hit_wr)) |-> evt_valid); // R5
endmodule

// File: tb/scl_stretch_mon_tb.sv
module scl_stretch_mon_tb;
  localparam int CNT_W = 16, EVT_W = 16, ID_W = 8, BIT_W = 4, IDLE_CYC = 8;
  localparam int LMAX = (1 << CNT_W) - 1;
  localparam int EMAX = (1 << EVT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_r = 1'b1, sda_r = 1'b1, rel = 1'b0, dir_rd = 1'b0, clr = 1'b0;
  logic [CNT_W-1:0] exp_low = 16'd10, thr = 16'd5;
  logic [BIT_W-1:0] bit_pos = '0;
  logic evt_valid, evt_ack, evt_rd, hit_rd, hit_wr, ibs, ias;
  logic [CNT_W-1:0] evt_ext, max_ext;
  logic [EVT_W-1:0] evt_cnt;
  logic [ID_W-1:0] txn_id;

  always #10 clk = ~clk;

  scl_stretch_mon #(.CNT_W(CNT_W), .EVT_W(EVT_W), .ID_W(ID_W), .BIT_W(BIT_W),
                    .IDLE_CYC(IDLE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_r), .sda_in(sda_r), .mst_rel(rel),
    .exp_low(exp_low), .thresh(thr), .dir_rd(dir_rd), .bit_pos(bit_pos),
    .stats_clr(clr), .evt_valid(evt_valid), .evt_ext(evt_ext), .evt_ack(evt_ack),
    .evt_rd(evt_rd), .max_ext(max_ext), .evt_cnt(evt_cnt), .hit_rd(hit_rd),
    .hit_wr(hit_wr), .txn_id(txn_id), .idle_before_start(ibs), .idle_after_stop(ias));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string nm, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  bit qs[$], qd[$];
  bit m_fs, m_fsp, m_fd, m_fdp, m_held, m_evt, m_ack, m_rd, m_hrd, m_hwr;
  bit m_intx, m_ibs, m_ias, m_armed;
  int m_low, m_ext, m_max, m_cnt, m_id, m_icnt;

  task automatic model_reset();
    qs = '{1, 1, 1, 1}; qd = '{1, 1, 1, 1};
    m_fs = 1; m_fsp = 1; m_fd = 1; m_fdp = 1; m_held = 0; m_evt = 0; m_ack = 0;
    m_rd = 0; m_hrd = 0; m_hwr = 0; m_intx = 0; m_ibs = 0; m_ias = 0; m_armed = 0;
    m_low = 0; m_ext = 0; m_max = 0; m_cnt = 0; m_id = 0; m_icnt = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit nfs, nfd, fall, rise, fire, st, sp;
      int ext;
      nfs = (qs[2] == qs[1] && qs[1] == qs[0]) ? qs[2] : m_fs;
      nfd = (qd[2] == qd[1] && qd[1] == qd[0]) ? qd[2] : m_fd;
      qs.push_back(scl_r); void'(qs.pop_front());
      qd.push_back(sda_r); void'(qd.pop_front());
      fall = !m_fs && m_fsp;
      rise = m_fs && !m_fsp;
      ext = (m_low > int'(exp_low)) ? m_low - int'(exp_low) : 0;
      fire = rise && m_held && (ext > int'(thr));
      m_evt = fire;
      if (fire) begin
        m_ext = ext; m_ack = (bit_pos == 8); m_rd = dir_rd;
        if (m_cnt < EMAX) m_cnt++;
      end
      if (clr) begin
        m_max = fire ? ext : 0; m_hrd = fire && dir_rd; m_hwr = fire && !dir_rd;
      end else if (fire) begin
        if (ext > m_max) m_max = ext;
        if (dir_rd) m_hrd = 1; else m_hwr = 1;
      end
      if (!m_fs) m_low = fall ? 1 : ((m_low < LMAX) ? m_low + 1 : LMAX);
      if (fall) m_held = rel; else if (!m_fs && rel) m_held = 1;
      st = m_fs && m_fsp && !m_fd && m_fdp;
      sp = m_fs && m_fsp && m_fd && !m_fdp;
      if (st) begin
        m_id = (m_id + 1) % (1 << ID_W); m_ibs = !m_intx; m_intx = 1; m_ias = 0; m_armed = 0;
      end else if (sp) begin
        m_intx = 0; m_ias = 0; m_armed = 1; m_icnt = 0;
      end else if (m_armed) begin
        if (m_fs && m_fd) begin
          if (m_icnt == IDLE_CYC - 1) begin m_ias = 1; m_armed = 0; end
          else m_icnt++;
        end else m_armed = 0;
      end
      m_fsp = m_fs; m_fdp = m_fd; m_fs = nfs; m_fd = nfd;
    end
  end

  always @(negedge clk) if (!done) begin
    chk("R3", "evt_valid", evt_valid, m_evt);
    chk("R2", "evt_ext", evt_ext, m_ext);
    chk("R4", "evt_ack", evt_ack, m_ack);
    chk("R5", "evt_rd", evt_rd, m_rd);
    chk("R5", "hit_rd", hit_rd, m_hrd);
    chk("R5", "hit_wr", hit_wr, m_hwr);
    chk("R6", "max_ext", max_ext, m_max);
    chk("R7", "evt_cnt", evt_cnt, m_cnt);
    chk("R8", "txn_id", txn_id, m_id);
    chk("R9", "idle_before_start", ibs, m_ibs);
    chk("R10", "idle_after_stop", ias, m_ias);
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL low phase of n cycles, master releases from cycle rel_at
  task automatic low_phase(int n, int rel_at, int bp, bit rd);
    bit released;
    released = (rel_at < n);
    bit_pos = BIT_W'(bp); dir_rd = rd; rel = 0; scl_r = 0;
    for (int i = 0; i < n; i++) begin
      if (i >= rel_at) rel = 1;
      @(negedge clk);
    end
    scl_r = 1; rel = released;
    wait_n(12);
    rel = 0;
  endtask

  task automatic do_start();
    sda_r = 0; wait_n(8);
  endtask

  task automatic do_stop();
    scl_r = 0; sda_r = 0; wait_n(8);
    scl_r = 1; wait_n(8);
    sda_r = 1;
  endtask

  initial begin
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    // R11: reset state
    chk("R11", "evt_cnt after reset", evt_cnt, 0);
    chk("R11", "max_ext after reset", max_ext, 0);
    chk("R11", "txn_id after reset", txn_id, 0);
    chk("R11", "flags after reset", {evt_valid, hit_rd, hit_wr, ibs, ias}, 0);

    do_start();
    chk("R8", "txn_id after first START", txn_id, 1);
    chk("R9", "idle_before_start first", ibs, 1);

    low_phase(12, 6, 2, 0);           // excess 2: no event
    chk("R3", "no event below threshold", evt_cnt, 0);

    low_phase(30, 10, 8, 1);          // excess 20 at ACK slot, read
    chk("R2", "excess 30-10", evt_ext, 20);
    chk("R4", "ack tag", evt_ack, 1);
    chk("R5", "read hit", hit_rd, 1);
    chk("R7", "count after first event", evt_cnt, 1);

    low_phase(16, 8, 3, 0);           // excess 6 at bit 3, write
    chk("R4", "data-bit tag", evt_ack, 0);
    chk("R5", "write tag", evt_rd, 0);
    chk("R5", "write hit", hit_wr, 1);
    chk("R6", "max keeps larger", max_ext, 20);

    low_phase(15, 8, 5, 0);           // excess equals threshold
    chk("R3", "excess equal to threshold", evt_cnt, 2);

    low_phase(40, 1000, 5, 1);        // never released by master
    chk("R3", "no event without release", evt_cnt, 2);

    // R1: two-cycle high blip inside a 42-cycle low must be ignored
    bit_pos = 4'd1; dir_rd = 1; rel = 0; scl_r = 0;
    wait_n(10); rel = 1; wait_n(10);
    scl_r = 1; wait_n(2); scl_r = 0; wait_n(20);
    scl_r = 1; wait_n(12); rel = 0;
    chk("R1", "glitch ignored, one long phase", evt_ext, 32);
    chk("R6", "max after long phase", max_ext, 32);

    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    wait_n(1);
    chk("R6", "max cleared", max_ext, 0);
    chk("R6", "hits cleared", {hit_rd, hit_wr}, 0);
    chk("R7", "count kept over clear", evt_cnt, 3);

    // repeated START
    scl_r = 0; wait_n(6); sda_r = 1; wait_n(6); scl_r = 1; wait_n(8);
    do_start();
    chk("R8", "txn_id after repeated START", txn_id, 2);
    chk("R9", "repeated START not idle", ibs, 0);

    do_stop();
    wait_n(20);
    chk("R10", "idle after STOP window", ias, 1);

    do_start();
    chk("R9", "START after STOP idle", ibs, 1);
    do_stop();
    wait_n(3);
    do_start();
    chk("R10", "START inside window clears", ias, 0);
    chk("R8", "txn_id count", txn_id, 4);

    // R2: saturation of a very long hold
    low_phase(70000, 5, 8, 1);
    chk("R2", "saturated excess", evt_ext, LMAX - 10);
    chk("R6", "max after saturation", max_ext, LMAX - 10);
    wait_n(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule